// File: doc/BRIEF.md
# Pin Edge Timestamp Capture Unit

The unit watches ten general-purpose input pins and, whenever an armed edge arrives on one of them, freezes the current local time into a storage slot that belongs to that pin and that edge direction. Each pin owns one rising-edge slot and one falling-edge slot. Each slot holds 32 bits of seconds and 30 bits of nanoseconds. The time value is taken from a time bus driven by an external local time counter. A capture also records which edge came last on that pin, and it raises a pending capture interrupt.

Software reaches the unit through a small 16-bit register port. The register read data is combinational from the address. It arms rising and falling edges pin by pin and enables the interrupt line. It then picks one pin through a select register and reads that pin's two slots as 16-bit halves.

The interrupt pending flag is a two-state machine:
- `IRQ_IDLE` moves to `IRQ_PEND` on transition EV_CAPTURE, which is any capture.
- `IRQ_PEND` returns to `IRQ_IDLE` on transition EV_STAT_READ, a read of the status register in a cycle with no capture.
- `IRQ_PEND` stays in `IRQ_PEND` on EV_HOLD, which is every other cycle.

Register map (4-bit address):
- 0: capture status. Bit 2 is the pending flag. Reading this register clears the flag.
- 1: interrupt enable, bit 2.
- 2: rising arm, bit p for pin p.
- 3: falling arm, bit p for pin p.
- 4: pin select, field [11:8].
- 5: last-edge flags, bit p for pin p.
- 8 to 11: selected pin's rising slot, in the order seconds high, seconds low, nanoseconds high, nanoseconds low.
- 12 to 15: selected pin's falling slot, in the same order.

Top module: `gcap_unit`

## Requirements
- R1: After reset, every slot, the arm registers, the pin select, the last-edge flags and the pending flag are zero, and `cap_irq_o` is low.
- R2: A rising edge on pin p with rising arm bit p set stores into p's rising slot the time present on the time bus at the third clock edge after the pin input changes.
- R3: A falling edge on pin p with falling arm bit p set stores the time into p's falling slot, with the same latency as R2.
- R4: An edge whose arm bit is clear changes no slot, no last-edge flag and not the pending flag.
- R5: On a capture, bit p of register 5 becomes 1 for a rising edge and 0 for a falling edge.
- R6: Select field [11:8] of register 4 picks the pin whose slots appear at addresses 8 to 15. Writing 0 selects pin 0. A select value of 10 or more reads all slot words as zero.
- R7: A nanoseconds-high word carries nanoseconds bits [29:16] in bits [13:0], and its bits [15:14] read as zero.
- R8: Any capture sets bit 2 of register 0. `cap_irq_o` is high only while that flag is set and bit 2 of register 1 is set.
- R9: A read of register 0 clears the pending flag. When a capture and that read fall in the same cycle, the flag stays set.
- R10: A later armed edge of the same pin and direction overwrites that slot.
- R11: A capture on one pin leaves every other pin's slots unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_pin_i | input | 10 | Asynchronous pin inputs |
| now_sec_i | input | 32 | Local time, seconds |
| now_ns_i | input | 30 | Local time, nanoseconds |
| reg_addr_i | input | 4 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe (side effect on register 0 only) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, combinational from the address |
| cap_irq_o | output | 1 | Capture interrupt |

## Verification
The assertions check several properties on every cycle:
- each capture strobe loads exactly the time of that cycle into its slot;
- a slot without a strobe holds still;
- the last-edge flag follows the latest direction;
- the pending state machine sets, clears and holds on the named transitions;
- unselected and out-of-range readback is zero.

Only the bench scenarios can show the end-to-end latency through the synchroniser, the arm gating across both directions, and overwrites. They also cover isolation between pins and the same-cycle race between a capture and a status read.

// File: rtl/gcap_pkg.sv
package gcap_pkg;
    localparam int SEC_W   = 32;
    localparam int NS_W    = 30;
    localparam int REG_W   = 16;
    localparam int ADDR_W  = 4;
    localparam int SEL_W   = 4;
    localparam int SEL_LSB = 8;
    localparam int IRQ_BIT = 2;

    localparam logic [ADDR_W-1:0] A_STAT     = 4'd0;
    localparam logic [ADDR_W-1:0] A_IRQ_EN   = 4'd1;
    localparam logic [ADDR_W-1:0] A_RISE_ARM = 4'd2;
    localparam logic [ADDR_W-1:0] A_FALL_ARM = 4'd3;
    localparam logic [ADDR_W-1:0] A_SEL      = 4'd4;
    localparam logic [ADDR_W-1:0] A_LAST     = 4'd5;
    localparam logic [ADDR_W-1:0] A_R_SEC_HI = 4'd8;
    localparam logic [ADDR_W-1:0] A_R_SEC_LO = 4'd9;
    localparam logic [ADDR_W-1:0] A_R_NS_HI  = 4'd10;
    localparam logic [ADDR_W-1:0] A_R_NS_LO  = 4'd11;
    localparam logic [ADDR_W-1:0] A_F_SEC_HI = 4'd12;
    localparam logic [ADDR_W-1:0] A_F_SEC_LO = 4'd13;
    localparam logic [ADDR_W-1:0] A_F_NS_HI  = 4'd14;
    localparam logic [ADDR_W-1:0] A_F_NS_LO  = 4'd15;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } stamp_t;

    typedef enum logic {IRQ_IDLE, IRQ_PEND} irq_state_e;
endpackage

// File: rtl/gcap_edge.sv
module gcap_edge #(
    parameter int NUM_PINS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] rise_o,
    output logic [NUM_PINS-1:0] fall_o
);
    logic [NUM_PINS-1:0] meta_q, sync_q, prev_q;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[g] <= 1'b0;
                sync_q[g] <= 1'b0;
                prev_q[g] <= 1'b0;
            end else begin
                meta_q[g] <= pin_i[g];
                sync_q[g] <= meta_q[g];
                prev_q[g] <= sync_q[g];
            end
        end
        assign rise_o[g] = sync_q[g] & ~prev_q[g];
        assign fall_o[g] = ~sync_q[g] & prev_q[g];

        // R2: a detected rise reflects a pin level sampled two edges earlier
        p_rise_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[g] |-> $past(meta_q[g]));
    end
endmodule

// File: rtl/gcap_slot.sv
module gcap_slot
    import gcap_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cap_rise_i,
    input  logic   cap_fall_i,
    input  stamp_t now_i,
    output stamp_t rise_o,
    output stamp_t fall_o,
    output logic   last_rise_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_o      <= '0;
            fall_o      <= '0;
            last_rise_o <= 1'b0;
        end else begin
            if (cap_rise_i) begin
                rise_o      <= now_i;
                last_rise_o <= 1'b1;
            end
            if (cap_fall_i) begin
                fall_o      <= now_i;
                last_rise_o <= 1'b0;
            end
        end
    end

    p_latch_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_rise_i |=> rise_o == $past(now_i));
    p_latch_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fall_i |=> fall_o == $past(now_i));
    p_hold_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_rise_i |=> $stable(rise_o));
    p_hold_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_fall_i |=> $stable(fall_o));
    p_last_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fall_i |=> !last_rise_o);
endmodule

// File: rtl/gcap_irq.sv
module gcap_irq
    import gcap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap_any_i,
    input  logic stat_rd_i,
    input  logic irq_en_i,
    output logic pend_o,
    output logic irq_o
);
    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (cap_any_i) state_d = IRQ_PEND;                 // EV_CAPTURE
            IRQ_PEND: if (stat_rd_i && !cap_any_i) state_d = IRQ_IDLE;   // EV_STAT_READ, else EV_HOLD
            default:  state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pend_o = (state_q == IRQ_PEND);
        irq_o  = pend_o & irq_en_i;
    end

    p_set_on_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_any_i |=> state_q == IRQ_PEND);
    p_clear_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !cap_any_i) |=> state_q == IRQ_IDLE);
    p_hold_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_PEND && !stat_rd_i) |=> state_q == IRQ_PEND);
endmodule

// File: rtl/gcap_unit.sv
module gcap_unit
    import gcap_pkg::*;
#(
    parameter int NUM_PINS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] cap_pin_i,
    input  logic [SEC_W-1:0]    now_sec_i,
    input  logic [NS_W-1:0]     now_ns_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic                reg_wr_i,
    input  logic                reg_rd_i,
    input  logic [REG_W-1:0]    reg_wdata_i,
    output logic [REG_W-1:0]    reg_rdata_o,
    output logic                cap_irq_o
);
    localparam logic [SEL_W-1:0] SEL_LIMIT = SEL_W'(NUM_PINS);
    localparam int NS_HI_W = NS_W - 16;

    logic                irq_en_q;
    logic [NUM_PINS-1:0] rise_arm_q, fall_arm_q;
    logic [SEL_W-1:0]    sel_q;
    logic [NUM_PINS-1:0] rise_det, fall_det, cap_rise, cap_fall, last_rise;
    logic                pend, stat_rd, sel_ok;
    stamp_t              now, r_sel, f_sel;
    stamp_t              rise_st [NUM_PINS];
    stamp_t              fall_st [NUM_PINS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en_q   <= 1'b0;
            rise_arm_q <= '0;
            fall_arm_q <= '0;
            sel_q      <= '0;
        end else if (reg_wr_i) begin
            unique case (reg_addr_i)
                A_IRQ_EN:   irq_en_q   <= reg_wdata_i[IRQ_BIT];
                A_RISE_ARM: rise_arm_q <= reg_wdata_i[NUM_PINS-1:0];
                A_FALL_ARM: fall_arm_q <= reg_wdata_i[NUM_PINS-1:0];
                A_SEL:      sel_q      <= reg_wdata_i[SEL_LSB +: SEL_W];
                default:    ;
            endcase
        end
    end

    assign now      = '{sec: now_sec_i, ns: now_ns_i};
    assign cap_rise = rise_det & rise_arm_q;
    assign cap_fall = fall_det & fall_arm_q;
    assign stat_rd  = reg_rd_i && (reg_addr_i == A_STAT);

    gcap_edge #(.NUM_PINS(NUM_PINS)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin_i(cap_pin_i),
        .rise_o(rise_det), .fall_o(fall_det)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_slot
        gcap_slot u_slot (
            .clk(clk), .rst_n(rst_n),
            .cap_rise_i(cap_rise[g]), .cap_fall_i(cap_fall[g]),
            .now_i(now), .rise_o(rise_st[g]), .fall_o(fall_st[g]),
            .last_rise_o(last_rise[g])
        );
    end

    gcap_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .cap_any_i(|{cap_rise, cap_fall}), .stat_rd_i(stat_rd),
        .irq_en_i(irq_en_q), .pend_o(pend), .irq_o(cap_irq_o)
    );

    assign sel_ok = (sel_q < SEL_LIMIT);

    always_comb begin
        r_sel = '0;
        f_sel = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (sel_ok && sel_q == SEL_W'(i)) begin
                r_sel = rise_st[i];
                f_sel = fall_st[i];
            end
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            A_STAT:     reg_rdata_o[IRQ_BIT] = pend;
            A_IRQ_EN:   reg_rdata_o[IRQ_BIT] = irq_en_q;
            A_RISE_ARM: reg_rdata_o = REG_W'(rise_arm_q);
            A_FALL_ARM: reg_rdata_o = REG_W'(fall_arm_q);
            A_SEL:      reg_rdata_o[SEL_LSB +: SEL_W] = sel_q;
            A_LAST:     reg_rdata_o = REG_W'(last_rise);
            A_R_SEC_HI: reg_rdata_o = r_sel.sec[31:16];
            A_R_SEC_LO: reg_rdata_o = r_sel.sec[15:0];
            A_R_NS_HI:  reg_rdata_o = REG_W'(r_sel.ns[NS_W-1:16]);
            A_R_NS_LO:  reg_rdata_o = r_sel.ns[15:0];
            A_F_SEC_HI: reg_rdata_o = f_sel.sec[31:16];
            A_F_SEC_LO: reg_rdata_o = f_sel.sec[15:0];
            A_F_NS_HI:  reg_rdata_o = REG_W'(f_sel.ns[NS_W-1:16]);
            A_F_NS_LO:  reg_rdata_o = f_sel.ns[15:0];
            default:    reg_rdata_o = '0;
        endcase
    end

    p_unsel_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ok && reg_addr_i[3]) |-> reg_rdata_o == '0);
    p_ns_hi_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == A_R_NS_HI || reg_addr_i == A_F_NS_HI)
            |-> reg_rdata_o[REG_W-1:NS_HI_W] == '0);
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_q |-> !cap_irq_o);
endmodule

// File: tb/tb_gcap_unit.sv
module tb_gcap_unit;
    import gcap_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  pins = '0;
    logic [31:0] now_sec = '0;
    logic [29:0] now_ns = '0;
    logic [3:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0, fails = 0, tcnt = 0;
    bit done = 0;

    logic [31:0] e_rs [10];
    logic [31:0] e_fs [10];
    logic [29:0] e_rn [10];
    logic [29:0] e_fn [10];
    logic [9:0]  e_last = '0;

    always #2.5 clk = ~clk;

    gcap_unit dut (
        .clk(clk), .rst_n(rst_n), .cap_pin_i(pins), .now_sec_i(now_sec),
        .now_ns_i(now_ns), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cap_irq_o(irq)
    );

    function automatic logic [31:0] f_sec(int t); return 32'h5EC0_0000 + 32'(t); endfunction
    function automatic logic [29:0] f_ns(int t);  return 30'h1234_0000 + 30'(t * 7); endfunction

    initial forever begin
        @(negedge clk);
        tcnt++;
        now_sec = f_sec(tcnt);
        now_ns  = f_ns(tcnt);
    end

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wreg(logic [3:0] a, logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(posedge clk); #1 wr = 1'b0;
    endtask

    task automatic rreg(logic [3:0] a, output logic [15:0] v);
        @(negedge clk); addr = a; rd = 1'b1;
        #1 v = rdata;
        @(posedge clk); #1 rd = 1'b0;
    endtask

    task automatic drive_pin(int p, logic lvl, output int t);
        @(negedge clk); #1;
        t = tcnt;
        pins[p] = lvl;
    endtask

    task automatic check_pin(int p, string req);
        logic [15:0] v;
        wreg(A_SEL, 16'(p) << 8);
        rreg(A_R_SEC_HI, v); chk(req, v, e_rs[p][31:16]);
        rreg(A_R_SEC_LO, v); chk(req, v, e_rs[p][15:0]);
        rreg(A_R_NS_HI,  v); chk(req, v, {2'b00, e_rn[p][29:16]});
        rreg(A_R_NS_LO,  v); chk(req, v, e_rn[p][15:0]);
        rreg(A_F_SEC_HI, v); chk(req, v, e_fs[p][31:16]);
        rreg(A_F_SEC_LO, v); chk(req, v, e_fs[p][15:0]);
        rreg(A_F_NS_HI,  v); chk(req, v, {2'b00, e_fn[p][29:16]});
        rreg(A_F_NS_LO,  v); chk(req, v, e_fn[p][15:0]);
    endtask

    // entry: pin[6:3], level[2], rising arm[1], falling arm[0]
    localparam logic [6:0] VEC [8] = '{
        {4'd0, 1'b1, 1'b1, 1'b0},
        {4'd0, 1'b0, 1'b1, 1'b1},
        {4'd9, 1'b1, 1'b0, 1'b1},
        {4'd9, 1'b0, 1'b1, 1'b1},
        {4'd5, 1'b1, 1'b1, 1'b1},
        {4'd0, 1'b1, 1'b1, 1'b1},
        {4'd3, 1'b1, 1'b0, 1'b0},
        {4'd3, 1'b0, 1'b0, 1'b1}
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int t;
        for (int i = 0; i < 10; i++) begin
            e_rs[i] = '0; e_fs[i] = '0; e_rn[i] = '0; e_fn[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1 chk("R1 irq", 16'(irq), 16'h0);
        rreg(A_STAT, v);     chk("R1 stat", v, 16'h0);
        rreg(A_LAST, v);     chk("R1 last", v, 16'h0);
        rreg(A_SEL, v);      chk("R1 sel", v, 16'h0);
        rreg(A_RISE_ARM, v); chk("R1 arm", v, 16'h0);
        check_pin(0, "R1 slot");

        wreg(A_IRQ_EN, 16'h0004);

        for (int i = 0; i < 8; i++) begin
            int p;
            logic lvl, ra, fa, cap;
            string tag;
            p = int'(VEC[i][6:3]); lvl = VEC[i][2]; ra = VEC[i][1]; fa = VEC[i][0];
            wreg(A_RISE_ARM, ra ? (16'h1 << p) : 16'h0);
            wreg(A_FALL_ARM, fa ? (16'h1 << p) : 16'h0);
            drive_pin(p, lvl, t);
            repeat (3) @(posedge clk);
            cap = lvl ? ra : fa;
            tag = !cap ? "R4" : (lvl ? "R2" : "R3");
            if (cap) begin
                if (lvl) begin e_rs[p] = f_sec(t + 2); e_rn[p] = f_ns(t + 2); end
                else     begin e_fs[p] = f_sec(t + 2); e_fn[p] = f_ns(t + 2); end
                e_last[p] = lvl;
            end
            @(negedge clk); #1 chk("R8 irq line", 16'(irq), 16'(cap));
            rreg(A_STAT, v); chk("R8 stat", v, cap ? 16'h0004 : 16'h0);
            rreg(A_LAST, v); chk("R5 last edge", v, 16'(e_last));
            check_pin(p, tag);
        end

        // R10: pin 0 rising slot was overwritten by the later rising edge
        check_pin(0, "R10");
        // R11: every pin still holds only its own captures
        for (int p = 0; p < 10; p++) check_pin(p, "R11");

        // R9: capture in the same cycle as a status read keeps the flag
        wreg(A_RISE_ARM, 16'h0080);
        wreg(A_FALL_ARM, 16'h0080);
        drive_pin(7, 1'b1, t);
        repeat (2) @(posedge clk);
        rreg(A_STAT, v); chk("R9 before", v, 16'h0);
        rreg(A_STAT, v); chk("R9 race", v, 16'h0004);
        rreg(A_STAT, v); chk("R9 cleared", v, 16'h0);
        e_rs[7] = f_sec(t + 2); e_rn[7] = f_ns(t + 2); e_last[7] = 1'b1;
        check_pin(7, "R9");

        // R8: enable off masks the line but not the flag
        wreg(A_IRQ_EN, 16'h0);
        drive_pin(7, 1'b0, t);
        repeat (3) @(posedge clk);
        e_fs[7] = f_sec(t + 2); e_fn[7] = f_ns(t + 2); e_last[7] = 1'b0;
        @(negedge clk); #1 chk("R8 masked", 16'(irq), 16'h0);
        rreg(A_STAT, v); chk("R8 flag", v, 16'h0004);

        // R6: out-of-range select reads zero; select 0 returns to pin 0
        wreg(A_SEL, 16'h0C00);
        rreg(A_SEL, v);      chk("R6 sel", v, 16'h0C00);
        rreg(A_R_SEC_HI, v); chk("R6 range", v, 16'h0);
        rreg(A_F_NS_LO, v);  chk("R6 range", v, 16'h0);
        wreg(A_SEL, 16'h0000);
        rreg(A_R_SEC_LO, v); chk("R6 pin0", v, e_rs[0][15:0]);

        // R7: nanoseconds-high upper bits read zero
        rreg(A_R_NS_HI, v); chk("R7", v & 16'hC000, 16'h0);
        rreg(A_R_NS_HI, v); chk("R7", v, {2'b00, e_rn[0][29:16]});

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule